// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory instruction into the stream of element addresses that a banked memory consumes. Software-visible settings arrive with a start pulse: an addressing mode, an element width, a vector length, a base address, a byte stride and a post-instruction increment. The block then walks the elements in ascending order. In the contiguous and constant-stride modes it emits up to four addresses per clock. In the gather/scatter mode it adds one offset per clock, taken from an index stream with a valid/ready handshake, to the base.

The memory behind the block has eight banks that are interleaved on 8-byte words. Two addresses in the same clock that fall in the same bank would collide. For this reason each clock's group is cut short at the first lane that repeats a bank already used in that group, and the cut-off elements wait for a later clock. When the final element has gone out, the block pulses a completion flag and presents the base address advanced by the increment. The issuing side uses that value to update its base register.

Top module: `vag_addr_gen`

## Requirements
- R1: After reset, busy, done, addr_vld and base_upd are all zero.
- R2: With mode 2'b00 (contiguous), element i has address base + i * B modulo 2^AW. B is 1, 2, 4 or 8 bytes for ew codes 0, 1, 2 and 3.
- R3: With mode 2'b01 (constant stride), element i has address base + i * stride modulo 2^AW. The stride is a byte count.
- R4: With mode[1] = 1 (indexed), each accepted index beat (idx_valid and idx_ready) issues exactly one address, base + idx_off, on lane 0. Offsets are used in arrival order. idx_ready is high only while an indexed instruction is busy, and no address is issued in a cycle where idx_valid is low.
- R5: Each cycle, the lanes carry consecutive elements in ascending order, and elem_base gives the element number on lane 0. addr_vld is a contiguous run of ones starting at lane 0, it holds at most four lanes, and it is nonzero only while busy.
- R6: The bank of an address is addr[5:3]. In the contiguous and strided modes, every cycle issues the longest run of pending elements, up to four, whose banks are all different.
- R7: The effective length is vlen clamped to a maximum of 128, 128, 64 or 32 for ew codes 0, 1, 2 and 3.
- R8: done is a one-cycle pulse in the cycle after the last address is issued. In that same cycle, base_upd equals base + incr modulo 2^AW and busy is low.
- R9: An effective length of zero issues no address and raises done in the cycle after start, with base_upd equal to the unchanged base.
- R10: A start pulse while busy is ignored, and the running instruction continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins an instruction when idle |
| mode | input | 2 | 00 contiguous, 01 strided, 1x indexed |
| ew | input | 2 | Element width code: 0=8b, 1=16b, 2=32b, 3=64b |
| vlen | input | 8 | Requested element count |
| base_in | input | 32 | Base byte address |
| stride_in | input | 32 | Byte stride for strided mode |
| incr_in | input | 32 | Base increment applied at completion |
| idx_valid | input | 1 | Index offset available |
| idx_ready | output | 1 | Block accepts an index offset |
| idx_off | input | 32 | Byte offset for indexed mode |
| addr_vld | output | 4 | Per-lane address valid, a prefix mask |
| addr_bus | output | 128 | Lane k address in bits [32k+31:32k] |
| elem_base | output | 8 | Element number carried on lane 0 |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Completion pulse |
| base_upd | output | 32 | Updated base, valid with done |

## Verification
The hardest case to reach is a bank clash partway through a group. This happens when lane 2 or lane 3 repeats the bank of an earlier lane, so the group has to be shortened without losing or reordering any element. The stimulus gets there with strides that are multiples of 8 bytes chosen to wrap the bank field at different rates, with random strides and with narrow contiguous elements, and every group size is compared against a bench-side model of the longest distinct-bank run. A second hard case is a start pulse that lands in the middle of a long instruction: the bench drives one with different settings while busy and keeps checking the original address sequence. Indexed runs hold idx_valid low on random cycles to test the stall path.

// File: rtl/vag_pkg.sv
package vag_pkg;

    typedef enum logic [1:0] {
        MD_CONTIG = 2'b00,
        MD_STRIDE = 2'b01,
        MD_INDEX  = 2'b10,
        MD_INDEXB = 2'b11
    } vag_mode_e;

    // Largest element count allowed for a width code: the register budget
    // is constant in bytes once elements are wider than 16 bits.
    function automatic int max_len(input logic [1:0] ew_code, input int maxvl);
        if (ew_code < 2'd2)
            return maxvl;
        return maxvl >> (int'(ew_code) - 1);
    endfunction

endpackage

// File: rtl/vag_lane_calc.sv
module vag_lane_calc #(
    parameter int AW    = 32,
    parameter int LANES = 4
) (
    input  logic                      idx_mode,
    input  logic [AW-1:0]             cur,
    input  logic [AW-1:0]             step,
    input  logic [AW-1:0]             base,
    input  logic [AW-1:0]             offset,
    output logic [LANES-1:0][AW-1:0]  lane_addr
);
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k == 0) begin : g_first
            // Lane 0 serves both the gather path and the strided walk.
            assign lane_addr[k] = idx_mode ? (base + offset) : cur;
        end else begin : g_rest
            assign lane_addr[k] = idx_mode ? '0 : (cur + AW'(k) * step);
        end
    end
endmodule

// File: rtl/vag_bank_arb.sv
module vag_bank_arb #(
    parameter int LANES  = 4,
    parameter int BW     = 3,
    localparam int CW    = $clog2(LANES + 1)
) (
    input  logic [LANES-1:0]          cand,
    input  logic [LANES-1:0][BW-1:0]  bank,
    output logic [LANES-1:0]          grant,
    output logic [CW-1:0]             count
);
    always_comb begin
        logic run_ok;
        logic clash;
        run_ok = 1'b1;
        grant  = '0;
        count  = '0;
        for (int k = 0; k < LANES; k++) begin
            clash = 1'b0;
            for (int j = 0; j < LANES; j++) begin
                if (j < k && bank[j] == bank[k])
                    clash = 1'b1;
            end
            // The first clash ends the run so elements stay in order.
            run_ok   = run_ok & cand[k] & ~clash;
            grant[k] = run_ok;
            if (run_ok)
                count = count + CW'(1);
        end
    end
endmodule

// File: rtl/vag_addr_gen.sv
module vag_addr_gen #(
    parameter int AW         = 32,
    parameter int LANES      = 4,
    parameter int NBANKS     = 8,
    parameter int BANK_SHIFT = 3,
    parameter int MAXVL      = 128,
    localparam int VLW       = $clog2(MAXVL + 1),
    localparam int BW        = $clog2(NBANKS),
    localparam int CW        = $clog2(LANES + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            mode,
    input  logic [1:0]            ew,
    input  logic [VLW-1:0]        vlen,
    input  logic [AW-1:0]         base_in,
    input  logic [AW-1:0]         stride_in,
    input  logic [AW-1:0]         incr_in,
    input  logic                  idx_valid,
    output logic                  idx_ready,
    input  logic [AW-1:0]         idx_off,
    output logic [LANES-1:0]      addr_vld,
    output logic [LANES*AW-1:0]   addr_bus,
    output logic [VLW-1:0]        elem_base,
    output logic                  busy,
    output logic                  done,
    output logic [AW-1:0]         base_upd
);
    import vag_pkg::*;

    typedef struct packed {
        logic            busy;
        logic            idx;
        logic            done;
        logic [AW-1:0]   step;
        logic [AW-1:0]   base;
        logic [AW-1:0]   incr;
        logic [AW-1:0]   cur;
        logic [AW-1:0]   base_upd;
        logic [VLW-1:0]  len;
        logic [VLW-1:0]  cnt;
    } vag_state_t;

    vag_state_t st_q, st_d;

    logic [LANES-1:0][AW-1:0] lane_addr;
    logic [LANES-1:0][BW-1:0] lane_bank;
    logic [LANES-1:0]         cand;
    logic [LANES-1:0]         grant;
    logic [CW-1:0]            grp_cnt;
    logic [VLW-1:0]           remain;
    logic [VLW-1:0]           len_clamped;

    vag_lane_calc #(.AW(AW), .LANES(LANES)) lane_calc_i (
        .idx_mode  (st_q.idx),
        .cur       (st_q.cur),
        .step      (st_q.step),
        .base      (st_q.base),
        .offset    (idx_off),
        .lane_addr (lane_addr)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_bank
        assign lane_bank[k]           = lane_addr[k][BANK_SHIFT +: BW];
        assign addr_bus[k*AW +: AW]   = lane_addr[k];
    end

    assign remain = st_q.len - st_q.cnt;

    always_comb begin
        cand = '0;
        if (st_q.busy) begin
            if (st_q.idx) begin
                cand[0] = idx_valid;
            end else begin
                for (int k = 0; k < LANES; k++)
                    cand[k] = (k < int'(remain));
            end
        end
    end

    vag_bank_arb #(.LANES(LANES), .BW(BW)) bank_arb_i (
        .cand  (cand),
        .bank  (lane_bank),
        .grant (grant),
        .count (grp_cnt)
    );

    always_comb begin
        int ml;
        ml = max_len(ew, MAXVL);
        if (int'(vlen) > ml)
            len_clamped = VLW'(ml);
        else
            len_clamped = vlen;
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.idx  = mode[1];
                st_d.step = (vag_mode_e'(mode) == MD_CONTIG) ? (AW'(1) << ew) : stride_in;
                st_d.base = base_in;
                st_d.incr = incr_in;
                st_d.cur  = base_in;
                st_d.cnt  = '0;
                st_d.len  = len_clamped;
                if (len_clamped == '0) begin
                    st_d.done     = 1'b1;
                    st_d.base_upd = base_in;
                end else begin
                    st_d.busy = 1'b1;
                end
            end
        end else begin
            st_d.cnt = st_q.cnt + VLW'(grp_cnt);
            st_d.cur = st_q.cur + AW'(grp_cnt) * st_q.step;
            if (st_d.cnt == st_q.len) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.base_upd = st_q.base + st_q.incr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign addr_vld  = grant;
    assign idx_ready = st_q.busy & st_q.idx;
    assign elem_base = st_q.cnt;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign base_upd  = st_q.base_upd;

endmodule

// File: rtl/vag_addr_gen_chk.sv
module vag_addr_gen_chk #(
    parameter int AW         = 32,
    parameter int LANES      = 4,
    parameter int NBANKS     = 8,
    parameter int BANK_SHIFT = 3,
    parameter int MAXVL      = 128,
    localparam int VLW       = $clog2(MAXVL + 1),
    localparam int BW        = $clog2(NBANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [VLW-1:0]       vlen,
    input logic [AW-1:0]        base_in,
    input logic                 idx_valid,
    input logic                 idx_ready,
    input logic [LANES-1:0]     addr_vld,
    input logic [LANES*AW-1:0]  addr_bus,
    input logic                 busy,
    input logic                 done,
    input logic [AW-1:0]        base_upd
);
    function automatic bit banks_distinct(input logic [LANES*AW-1:0] a,
                                          input logic [LANES-1:0] v);
        banks_distinct = 1'b1;
        for (int i = 0; i < LANES; i++)
            for (int j = 0; j < LANES; j++)
                if (i < j && v[i] && v[j] &&
                    a[i*AW + BANK_SHIFT +: BW] == a[j*AW + BANK_SHIFT +: BW])
                    banks_distinct = 1'b0;
    endfunction

    assert_prefix_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld & (addr_vld + LANES'(1))) == '0);

    assert_issue_needs_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_vld != '0) |-> busy);

    assert_banks_distinct_R6: assert property (@(posedge clk) disable iff (!rst_n)
        banks_distinct(addr_bus, addr_vld));

    assert_ready_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        idx_ready |-> busy);

    assert_index_single_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_ready && addr_vld != '0) |-> (idx_valid && addr_vld == LANES'(1)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_end_has_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    assert_empty_instr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && vlen == '0) |=> (done && !busy && base_upd == $past(base_in)));

    assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> !done || !busy);

endmodule

bind vag_addr_gen vag_addr_gen_chk #(
    .AW(AW), .LANES(LANES), .NBANKS(NBANKS), .BANK_SHIFT(BANK_SHIFT), .MAXVL(MAXVL)
) chk_i (.*);

// File: tb/vag_addr_gen_tb.sv
module vag_addr_gen_tb_top;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start;
    logic [1:0]   mode;
    logic [1:0]   ew;
    logic [7:0]   vlen;
    logic [31:0]  base_in, stride_in, incr_in, idx_off;
    logic         idx_valid;
    logic         idx_ready;
    logic [3:0]   addr_vld;
    logic [127:0] addr_bus;
    logic [7:0]   elem_base;
    logic         busy, done;
    logic [31:0]  base_upd;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ea [0:127];
    logic [31:0] it [0:127];

    always #4 clk = ~clk;

    vag_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .ew(ew), .vlen(vlen),
        .base_in(base_in), .stride_in(stride_in), .incr_in(incr_in),
        .idx_valid(idx_valid), .idx_ready(idx_ready), .idx_off(idx_off),
        .addr_vld(addr_vld), .addr_bus(addr_bus), .elem_base(elem_base),
        .busy(busy), .done(done), .base_upd(base_upd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] bank_of(input logic [31:0] a);
        return a[5:3];
    endfunction

    function automatic int exp_group(input int ptr, input int len);
        int n;
        bit stop;
        n = 0;
        stop = 0;
        for (int k = 0; k < 4; k++) begin
            if (!stop) begin
                if (ptr + k >= len) stop = 1;
                for (int j = 0; j < k; j++)
                    if (!stop && bank_of(ea[ptr+j]) == bank_of(ea[ptr+k])) stop = 1;
                if (!stop) n++;
            end
        end
        return n;
    endfunction

    task automatic run(input logic [1:0] md, input logic [1:0] e, input int vl,
                       input logic [31:0] b, input logic [31:0] s,
                       input logic [31:0] inc, input bit poke, input string tag);
        int mlen, len, ptr, cyc, n;
        bit got;
        mlen = (e < 2) ? 128 : (128 >> (int'(e) - 1));
        len  = (vl > mlen) ? mlen : vl;
        for (int i = 0; i < 128; i++) begin
            it[i] = $urandom;
            if (md == 2'b00)      ea[i] = b + 32'(i) * (32'd1 << e);
            else if (md == 2'b01) ea[i] = b + 32'(i) * s;
            else                  ea[i] = b + it[i];
        end
        @(negedge clk);
        start = 1'b1; mode = md; ew = e; vlen = 8'(vl);
        base_in = b; stride_in = s; incr_in = inc;
        @(negedge clk);
        ptr = 0; cyc = 0; got = 0;
        while (!got && cyc < 2000) begin
            start = 1'b0;
            if (poke && cyc == 1) begin
                start = 1'b1; mode = 2'b01; vlen = 8'd3;
                base_in = 32'h5555_0000; stride_in = 32'h40; incr_in = 32'h1;
            end
            if (md[1]) begin
                idx_valid = (ptr < len) && (($urandom % 4) != 0);
                idx_off   = it[(ptr < len) ? ptr : 0];
            end
            #1;
            if (done) begin
                got = 1;
                chk(ptr == len, "R7", "element total", 64'(ptr), 64'(len));
                chk(base_upd == b + inc || len == 0, "R8", "base_upd", base_upd, b + inc);
                chk(!busy, "R8", "busy at done", busy, 0);
                if (len == 0) begin
                    chk(base_upd == b, "R9", "base kept", base_upd, b);
                    chk(cyc == 0, "R9", "done latency", cyc, 0);
                end
                if (poke)
                    chk(base_upd == b + inc, "R10", "base after poke", base_upd, b + inc);
            end else begin
                if (md[1]) n = idx_valid ? 1 : 0;
                else       n = exp_group(ptr, len);
                chk(busy == 1'b1, tag, "busy", busy, 1);
                chk(addr_vld == 4'((1 << n) - 1), md[1] ? "R4" : "R6", "addr_vld",
                    addr_vld, 64'((1 << n) - 1));
                chk(elem_base == 8'(ptr), "R5", "elem_base", elem_base, ptr);
                if (md[1]) chk(idx_ready == 1'b1, "R4", "idx_ready", idx_ready, 1);
                for (int k = 0; k < 4; k++)
                    if (k < n)
                        chk(addr_bus[k*32 +: 32] == ea[ptr+k], tag, "lane address",
                            addr_bus[k*32 +: 32], ea[ptr+k]);
                ptr += n;
                @(negedge clk);
                cyc++;
            end
        end
        if (!got) chk(0, tag, "watchdog, no done", 0, 1);
        start = 1'b0;
        idx_valid = 1'b0;
        @(negedge clk);
        #1;
        chk(!done, "R8", "done one cycle", done, 0);
        chk(addr_vld == 0 && idx_ready == 0, "R5", "idle outputs", {addr_vld, idx_ready}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL global watchdog expired act=1 exp=0");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0; start = 1'b0; mode = 0; ew = 0; vlen = 0;
        base_in = 0; stride_in = 0; incr_in = 0; idx_off = 0; idx_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!busy && !done && addr_vld == 0 && base_upd == 0, "R1", "reset state",
            {busy, done, addr_vld, base_upd}, 0);

        // Contiguous at each width, including wrap near the top of the space.
        run(2'b00, 2'd0, 20, 32'h0000_1000, 0, 32'h100, 0, "R2");
        run(2'b00, 2'd1, 37, 32'h0000_2002, 0, 32'h40, 0, "R2");
        run(2'b00, 2'd2, 64, 32'h0000_3004, 0, 32'h0, 0, "R2");
        run(2'b00, 2'd3, 9, 32'hFFFF_FFE0, 0, 32'h20, 0, "R2");
        // Strides chosen to hit no clash, full clash and mid-group clash.
        run(2'b01, 2'd2, 16, 32'h0000_0100, 32'h8, 32'h1, 0, "R3");
        run(2'b01, 2'd2, 12, 32'h0000_0200, 32'h40, 32'h2, 0, "R3");
        run(2'b01, 2'd1, 15, 32'h0000_0300, 32'h18, 32'h3, 0, "R3");
        run(2'b01, 2'd1, 15, 32'h0000_0300, 32'h20, 32'h3, 0, "R3");
        run(2'b01, 2'd0, 7, 32'h0000_0400, 32'h0, 32'h4, 0, "R3");
        run(2'b01, 2'd3, 10, 32'h0000_0500, 32'hFFFF_FFF8, 32'h5, 0, "R3");
        // Clamping of over-long lengths.
        run(2'b00, 2'd3, 128, 32'h0001_0000, 0, 32'h7, 0, "R7");
        run(2'b01, 2'd0, 200, 32'h0002_0000, 32'h28, 32'h9, 0, "R7");
        run(2'b00, 2'd2, 90, 32'h0003_0000, 0, 32'hA, 0, "R7");
        // Empty instructions, including a length clamped to zero is impossible,
        // so zero is requested directly in several modes.
        run(2'b00, 2'd0, 0, 32'h0004_0000, 0, 32'h10, 0, "R9");
        run(2'b10, 2'd2, 0, 32'h0005_0000, 0, 32'h10, 0, "R9");
        // Indexed with random valid gaps.
        run(2'b10, 2'd2, 30, 32'h0006_0000, 0, 32'h11, 0, "R4");
        run(2'b11, 2'd0, 5, 32'h0007_0000, 0, 32'h12, 0, "R4");
        // Start while busy must not disturb the running instruction.
        run(2'b01, 2'd2, 40, 32'h0008_0000, 32'h10, 32'h13, 1, "R10");
        run(2'b10, 2'd1, 20, 32'h0009_0000, 0, 32'h14, 1, "R10");

        for (int r = 0; r < 40; r++) begin
            logic [1:0]  md;
            logic [31:0] s;
            md = 2'($urandom % 3);
            s  = (($urandom % 2) == 0) ? ($urandom % 16) * 32'd8 : $urandom;
            run(md, 2'($urandom), int'($urandom % 161), $urandom, s, $urandom, 0,
                md == 2'b00 ? "R2" : (md == 2'b01 ? "R3" : "R4"));
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule